// File: doc/BRIEF.md
# Byte-Wide Flash Command Sequencer

This block is the device side of a byte-wide non-volatile memory that is steered through a single command register. A host drives a chip-select, an output-enable, a write strobe, an address and a data byte, all active-low strobes sampled on the block clock. A separate high-voltage-present input unlocks the command register. With that input low the register is held at the array-read code and the part behaves as a read-only store.

With high voltage present, written bytes select between array read, identifier read, whole-array erase, erase check, byte program, program check and a two-write abort. Erase and program run as timed pulses. A later verify write ends the pulse. If no verify arrives, an internal stop timer ends it after a fixed number of cycles.

The behavioural array is small; the low address bits index it. Because the bus is a strobe-driven memory port rather than a data stream, there is no valid/ready pair and no back-pressure. A write completes on the sampled rising edge of the write strobe. Read data follows the current mode combinationally while both enables are low.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, or whenever `hv_ok` is low, the mode is array read and no pulse runs. Writes made while `hv_ok` is low change neither the mode nor the array. Every array byte resets to FFh.
- R2: A write is accepted only when `we_n` is sampled falling with `ce_n` low. The address is taken at that fall and the data at the following sampled rise. A strobe with `ce_n` high has no effect.
- R3: `dout_en` is 1 only while both `ce_n` and `oe_n` are low. Otherwise `dout` is 00h.
- R4: After command 90h, a read at address 0 returns 20h, a read at address 1 returns 07h, and any other address returns 00h.
- R5: Two consecutive writes of 20h start an erase pulse (`busy`=1). The pulse sets array bytes to FFh one per clock, from index 0 upward.
- R6: A write of A0h ends any running pulse and latches its own address. Reads then return the array byte at that latched address, whatever the bus address.
- R7: After command 40h, the next write (data other than FFh) starts a program pulse and stores old AND data at its address.
- R8: A write of C0h ends any running pulse. Reads then return the byte at the address latched by the last program write.
- R9: Two consecutive writes of FFh return to array read and end any pulse. An FFh written right after 40h or 20h is taken as the first of these two writes, so nothing is programmed or erased.
- R10: A pulse that no write ends drops `busy` after TIMER_LIMIT clock cycles. The mode is kept, so a following C0h or A0h still verifies.
- R11: Any byte outside 00h, 20h, 40h, 90h, A0h, C0h and FFh returns the block to array read. A 20h set-up followed by another code decodes that code as a new command.
- R12: Command 00h selects array read; reads return the byte at the bus address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all bus pins are sampled on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| hv_ok | input | 1 | High programming voltage present; low locks the command register |
| ce_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write strobe, active low |
| addr | input | ADDR_W (17) | Byte address |
| din | input | DATA_W (8) | Write data / command byte |
| dout | output | DATA_W (8) | Read data, 00h when not driven |
| dout_en | output | 1 | Read data is being driven |
| busy | output | 1 | Program or erase pulse running |

## Verification
The hardest state to reach is an erase pulse cut short in mid-sweep. Here some bytes already hold FFh while others keep their programmed value. The stimulus first programs bytes at index 0 and 60 to 00h. It then starts an erase and sends the A0h write at index 60 at once, a few clocks into the sweep. The verify read must still show 00h there, while a second verify at index 0 must show FFh. A related hidden case is the stop-timer expiry. That case is reached by starting a program pulse, idling past TIMER_LIMIT, and only then sending C0h, so the kept mode is seen through the verify read.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  typedef enum logic [3:0] {
    M_READ, M_SIG, M_ERS_SET, M_ERASE, M_EVFY,
    M_PGM_SET, M_PGM, M_PVFY, M_RST_SET
  } mode_e;

  localparam logic [7:0] C_READ   = 8'h00;
  localparam logic [7:0] C_SIG    = 8'h90;
  localparam logic [7:0] C_ERASE  = 8'h20;
  localparam logic [7:0] C_EVFY   = 8'hA0;
  localparam logic [7:0] C_PGM    = 8'h40;
  localparam logic [7:0] C_PVFY   = 8'hC0;
  localparam logic [7:0] C_RST    = 8'hFF;
  localparam logic [7:0] ID_MAKER = 8'h20;
  localparam logic [7:0] ID_PART  = 8'h07;
endpackage

// File: rtl/fcs_bus_sync.sv
module fcs_bus_sync #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_ok,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic [IDX_W-1:0]  addr,
  input  logic [DATA_W-1:0] din,
  output logic              wr_stb,
  output logic [IDX_W-1:0]  wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic we_q, armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q    <= 1'b1;
      armed   <= 1'b0;
      wr_stb  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      we_q   <= we_n;
      wr_stb <= 1'b0;
      if (!hv_ok) begin
        armed <= 1'b0;
      end else if (we_q && !we_n && !ce_n) begin
        armed   <= 1'b1;
        wr_addr <= addr;
      end else if (!we_q && we_n && armed) begin
        armed   <= 1'b0;
        wr_stb  <= 1'b1;
        wr_data <= din;
      end
    end
  end

  // R2: a completed write needs a fresh fall, so strobes never come back to back
  a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb);
endmodule

// File: rtl/fcs_cmd_fsm.sv
module fcs_cmd_fsm
  import fcs_pkg::*;
#(
  parameter int IDX_W       = 6,
  parameter int DATA_W      = 8,
  parameter int TIMER_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_ok,
  input  logic              wr_stb,
  input  logic [IDX_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output mode_e             mode,
  output logic              busy,
  output logic [IDX_W-1:0]  vfy_idx,
  output logic [IDX_W-1:0]  pgm_idx,
  output logic              pgm_we,
  output logic              erase_start,
  output logic              erase_on
);
  localparam int TW = $clog2(TIMER_LIMIT + 1);

  mode_e            mode_q;
  logic             pulse_q;
  logic [TW-1:0]    tmr_q;
  logic [IDX_W-1:0] vfy_q, pgm_q;

  function automatic mode_e decode(input logic [DATA_W-1:0] c);
    case (c)
      C_READ:  return M_READ;
      C_SIG:   return M_SIG;
      C_ERASE: return M_ERS_SET;
      C_EVFY:  return M_EVFY;
      C_PGM:   return M_PGM_SET;
      C_PVFY:  return M_PVFY;
      C_RST:   return M_RST_SET;
      default: return M_READ;
    endcase
  endfunction

  assign pgm_we      = wr_stb && hv_ok && mode_q == M_PGM_SET && wr_data != C_RST;
  assign erase_start = wr_stb && hv_ok && mode_q == M_ERS_SET && wr_data == C_ERASE;
  assign erase_on    = pulse_q && mode_q == M_ERASE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= M_READ;
      pulse_q <= 1'b0;
      tmr_q   <= '0;
      vfy_q   <= '0;
      pgm_q   <= '0;
    end else if (!hv_ok) begin
      mode_q  <= M_READ;
      pulse_q <= 1'b0;
      tmr_q   <= '0;
    end else if (wr_stb) begin
      tmr_q   <= '0;
      pulse_q <= 1'b0;
      if (pgm_we) begin
        mode_q  <= M_PGM;
        pulse_q <= 1'b1;
        pgm_q   <= wr_addr;
      end else if (erase_start) begin
        mode_q  <= M_ERASE;
        pulse_q <= 1'b1;
      end else if (mode_q == M_RST_SET && wr_data == C_RST) begin
        mode_q <= M_READ;
      end else begin
        mode_q <= decode(wr_data);
        if (wr_data == C_EVFY) vfy_q <= wr_addr;
      end
    end else if (pulse_q) begin
      if (tmr_q == TW'(TIMER_LIMIT - 1)) begin
        pulse_q <= 1'b0;
        tmr_q   <= '0;
      end else begin
        tmr_q <= tmr_q + 1'b1;
      end
    end
  end

  assign mode    = mode_q;
  assign busy    = pulse_q;
  assign vfy_idx = vfy_q;
  assign pgm_idx = pgm_q;

  // R1: losing high voltage forces array read with no pulse
  a_r1_hv_forces_read: assert property (@(posedge clk) disable iff (!rst_n)
    !hv_ok |=> (mode_q == M_READ && !pulse_q));
  // R7: an accepted program write starts a program pulse
  a_r7_prog_start: assert property (@(posedge clk) disable iff (!rst_n)
    pgm_we |=> (pulse_q && mode_q == M_PGM));
  // R10: a pulse at its last count with no write stops on the next clock
  a_r10_timer_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_q && hv_ok && !wr_stb && tmr_q == TW'(TIMER_LIMIT - 1)) |=> !pulse_q);
  // R6: a verify write always ends the pulse
  a_r6_verify_ends: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && hv_ok && mode_q != M_PGM_SET && (wr_data == C_EVFY || wr_data == C_PVFY))
      |=> !pulse_q);
endmodule

// File: rtl/fcs_array.sv
module fcs_array #(
  parameter int IDX_W  = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pgm_we,
  input  logic [IDX_W-1:0]  pgm_idx,
  input  logic [DATA_W-1:0] pgm_data,
  input  logic              erase_start,
  input  logic              erase_on,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [IDX_W-1:0]  ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      ptr_q <= '0;
    end else begin
      if (erase_start) ptr_q <= '0;
      if (pgm_we) begin
        mem[pgm_idx] <= mem[pgm_idx] & pgm_data;
      end else if (erase_on) begin
        mem[ptr_q] <= '1;
        ptr_q      <= ptr_q + 1'b1;
      end
    end
  end

  assign rd_data = mem[rd_idx];

  // R5: each erase clock leaves the swept byte fully set
  a_r5_erase_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_on && !pgm_we) |=> mem[$past(ptr_q)] == '1);
endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
  import fcs_pkg::*;
#(
  parameter int ADDR_W      = 17,
  parameter int DATA_W      = 8,
  parameter int ARR_AW      = 6,
  parameter int TIMER_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hv_ok,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic              dout_en,
  output logic              busy
);
  logic              wr_stb, pgm_we, erase_start, erase_on;
  logic [ARR_AW-1:0] wr_addr, vfy_idx, pgm_idx, rd_idx;
  logic [DATA_W-1:0] wr_data, rd_data, sig_val;
  mode_e             mode;

  fcs_bus_sync #(.IDX_W(ARR_AW), .DATA_W(DATA_W)) u_sync (
    .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .ce_n(ce_n), .we_n(we_n),
    .addr(addr[ARR_AW-1:0]), .din(din),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data));

  fcs_cmd_fsm #(.IDX_W(ARR_AW), .DATA_W(DATA_W), .TIMER_LIMIT(TIMER_LIMIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .mode(mode), .busy(busy),
    .vfy_idx(vfy_idx), .pgm_idx(pgm_idx), .pgm_we(pgm_we),
    .erase_start(erase_start), .erase_on(erase_on));

  fcs_array #(.IDX_W(ARR_AW), .DATA_W(DATA_W)) u_arr (
    .clk(clk), .rst_n(rst_n), .pgm_we(pgm_we), .pgm_idx(wr_addr),
    .pgm_data(wr_data), .erase_start(erase_start), .erase_on(erase_on),
    .rd_idx(rd_idx), .rd_data(rd_data));

  always_comb begin
    case (mode)
      M_EVFY:  rd_idx = vfy_idx;
      M_PVFY:  rd_idx = pgm_idx;
      default: rd_idx = addr[ARR_AW-1:0];
    endcase
    if (addr == '0)                   sig_val = ID_MAKER;
    else if (addr == ADDR_W'(1))      sig_val = ID_PART;
    else                              sig_val = '0;
  end

  assign dout_en = !ce_n && !oe_n;
  assign dout    = !dout_en ? '0 : (mode == M_SIG ? sig_val : rd_data);
endmodule

// File: tb/flash_cmd_seq_test.sv
module flash_cmd_seq_test;
  localparam int AW = 17, DW = 8, IW = 6, LIM = 200, DEPTH = 1 << IW;

  logic clk = 1'b0, rst_n = 1'b0, hv_ok = 1'b1;
  logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0, dout;
  logic dout_en, busy;
  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] rv;

  always #10 clk = ~clk;

  flash_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .ARR_AW(IW), .TIMER_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .hv_ok(hv_ok), .ce_n(ce_n), .oe_n(oe_n),
    .we_n(we_n), .addr(addr), .din(din), .dout(dout), .dout_en(dout_en),
    .busy(busy));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic sel = 1'b1);
    @(negedge clk); ce_n = !sel; addr = a; we_n = 1'b0;
    repeat (2) @(negedge clk); din = d; we_n = 1'b1;
    repeat (2) @(negedge clk); ce_n = 1'b1;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
    @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
    #4 v = dout;
    @(negedge clk); ce_n = 1'b1; oe_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R3 no drive while deselected", dout_en, 0);
    chk("R3 idle bus value", dout, 0);
    ce_n = 1'b0; #2; chk("R3 oe high keeps released", dout_en, 0); ce_n = 1'b1;
    chk("R1 no pulse after reset", busy, 0);
    rd(3, rv); chk("R1 reset array read", rv, 8'hFF);
  endtask

  task automatic t_signature();
    wr(0, 8'h90);
    rd(0, rv); chk("R4 maker id", rv, 8'h20);
    rd(1, rv); chk("R4 part id", rv, 8'h07);
    rd(2, rv); chk("R4 other address", rv, 8'h00);
    wr(0, 8'h00);
  endtask

  task automatic t_program();
    wr(0, 8'h40); wr(5, 8'hA5);
    chk("R7 program pulse running", busy, 1);
    wr(0, 8'hC0);
    chk("R8 verify ends pulse", busy, 0);
    rd(9, rv); chk("R8 verify reads program address", rv, 8'hA5);
    wr(0, 8'h40); wr(5, 8'h0F); wr(0, 8'hC0);
    rd(0, rv); chk("R7 program ANDs bits", rv, 8'h05);
    wr(0, 8'h00);
    rd(5, rv); chk("R12 read mode byte", rv, 8'h05);
    rd(9, rv); chk("R12 read mode other byte", rv, 8'hFF);
  endtask

  task automatic t_ce_ignore();
    wr(0, 8'h40, 1'b0);
    wr(9, 8'h00);
    rd(9, rv); chk("R2 deselected strobe ignored", rv, 8'hFF);
  endtask

  task automatic t_hv();
    hv_ok = 1'b0;
    wr(0, 8'h40); wr(10, 8'h00);
    rd(10, rv); chk("R1 writes locked without hv", rv, 8'hFF);
    hv_ok = 1'b1;
    wr(0, 8'h40); wr(11, 8'hF0);
    chk("R1 pulse before hv drop", busy, 1);
    @(negedge clk); hv_ok = 1'b0; repeat (3) @(negedge clk);
    chk("R1 hv drop ends pulse", busy, 0);
    hv_ok = 1'b1;
    rd(5, rv); chk("R1 hv drop returns read mode", rv, 8'h05);
  endtask

  task automatic t_abort();
    wr(0, 8'h40); wr(7, 8'hFF); wr(0, 8'hFF);
    chk("R9 abort leaves no pulse", busy, 0);
    rd(5, rv); chk("R9 abort returns read mode", rv, 8'h05);
    rd(7, rv); chk("R9 aborted byte untouched", rv, 8'hFF);
    wr(0, 8'h20); wr(0, 8'hFF); wr(0, 8'hFF);
    chk("R9 erase set-up aborted", busy, 0);
    rd(5, rv); chk("R9 no erase after abort", rv, 8'h05);
  endtask

  task automatic t_timer();
    wr(0, 8'h40); wr(12, 8'h3C);
    repeat (10) @(negedge clk);
    chk("R10 pulse still running", busy, 1);
    repeat (LIM + 10) @(negedge clk);
    chk("R10 stop timer ended pulse", busy, 0);
    wr(0, 8'hC0);
    rd(0, rv); chk("R10 verify after timeout", rv, 8'h3C);
    wr(0, 8'h00);
  endtask

  task automatic t_unknown();
    wr(0, 8'h90); wr(0, 8'h55);
    rd(0, rv); chk("R11 unknown code gives read mode", rv, 8'hFF);
    wr(0, 8'h20); wr(0, 8'h90);
    rd(1, rv); chk("R11 set-up followed by new command", rv, 8'h07);
    chk("R11 no erase started", busy, 0);
    wr(0, 8'h00);
  endtask

  task automatic t_erase_partial();
    wr(0, 8'h40); wr(0, 8'h00); wr(0, 8'hC0);
    wr(0, 8'h40); wr(60, 8'h00); wr(0, 8'hC0);
    wr(0, 8'h20); wr(0, 8'h20);
    chk("R5 erase pulse running", busy, 1);
    wr(60, 8'hA0);
    chk("R6 erase verify ends pulse", busy, 0);
    rd(3, rv); chk("R6 high byte not yet swept", rv, 8'h00);
    wr(0, 8'hA0);
    rd(3, rv); chk("R5 low byte erased first", rv, 8'hFF);
  endtask

  task automatic t_erase_full();
    wr(0, 8'h20); wr(0, 8'h20);
    repeat (DEPTH + 10) @(negedge clk);
    wr(60, 8'hA0);
    rd(0, rv); chk("R5 full sweep reaches high byte", rv, 8'hFF);
    wr(5, 8'hA0);
    rd(0, rv); chk("R5 programmed byte erased", rv, 8'hFF);
    wr(0, 8'hFF); wr(0, 8'hFF);
    rd(12, rv); chk("R5 array read after erase", rv, 8'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_signature();
    t_program();
    t_ce_ignore();
    t_hv();
    t_abort();
    t_timer();
    t_unknown();
    t_erase_partial();
    t_erase_full();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule